// File: doc/BRIEF.md
# Page Access Permission Checker

This unit decides whether one memory access may proceed once a page table entry has been found for it. Each request carries the access type, the privilege state, the key bits and no-execute bit of the segment, the protection fields of the page entry, and the two key-mask registers (one for data, one for instruction fetch). One clock after a request the unit returns the rights granted to the page. It also returns an allow flag or a fault flag. On a fault it gives a status word that names every source that refused the access.

Three independent sources set the granted rights, and the result is their AND. The first is a 3-bit page protection value qualified by the selected key. The second is a 2-bit field per class in the key-mask registers. The third is the no-execute and guarded bits of the entry. A fetch from a segment marked no-execute is refused before the other sources are consulted. The table walk and interrupt delivery sit outside this unit.

Top module: `perm_chk`

## Requirements
- R1: While rst_ni is low all outputs are 0. done_o equals req_valid_i from the previous clock. When done_o is 0, allow_o, fault_inst_o, fault_data_o, status_o and rights_o are 0.
- R2: The key is seg_key_user_i when user_mode_i is 1 and seg_key_sup_i otherwise. The protection value is {pte_pp0_i, pte_pp_i}. With key 0, values 0, 1 and 2 grant read, write and execute, and values 3 and 6 grant read and execute.
- R3: With key 1, value 2 grants read, write and execute, and values 1 and 3 grant read and execute. Every other value and key pair grants nothing.
- R4: pte_noexec_i or pte_guard_i removes execute only. Read and write are kept.
- R5: When mask_en_i is 1, the 2-bit field of dmask_i at bit position 2*(31-pte_class_i) is used. Its upper bit removes write and its lower bit removes read. Fields of other classes have no effect. When mask_en_i is 0, dmask_i has no effect.
- R6: The lower bit of the same field of imask_i removes execute, but only when both mask_en_i and imask_en_i are 1. The upper bit of the field has no effect.
- R7: rights_o is {x,w,r}, the AND of the three sources. acc_type_i selects the needed right: 0 is load (read), 1 is store (write), 2 is fetch (execute), and 3 is treated as a load. The access is allowed only if the needed right is granted.
- R8: On a refused fetch, fault_inst_o is 1. In status_o, bit 0 is set if no-execute or guarded refused execute. Otherwise bit 1 is set if the protection value refused it. Bit 2 is set in addition if the instruction mask refused it.
- R9: On a refused load or store, fault_data_o is 1. In status_o, bit 1 is set if the protection value refused the needed right, bit 3 is set for a store, and bit 2 is set if the data mask refused it.
- R10: A fetch with seg_noexec_i set faults with status_o equal to bits 4 and 0 only, whatever the page grants. Loads and stores ignore seg_noexec_i.
- R11: An allowed access has status_o equal to 0 and both fault flags clear. Exactly one of allow_o, fault_inst_o and fault_data_o is set while done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| acc_type_i | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| user_mode_i | input | 1 | Unprivileged access |
| seg_key_user_i | input | 1 | Segment key for unprivileged accesses |
| seg_key_sup_i | input | 1 | Segment key for privileged accesses |
| seg_noexec_i | input | 1 | Segment forbids instruction fetch |
| pte_pp_i | input | 2 | Low page protection bits |
| pte_pp0_i | input | 1 | High page protection bit |
| pte_noexec_i | input | 1 | Page no-execute bit |
| pte_guard_i | input | 1 | Page guarded bit |
| pte_class_i | input | 5 | Class key of the page |
| dmask_i | input | 64 | Data key-mask register |
| imask_i | input | 64 | Instruction key-mask register |
| mask_en_i | input | 1 | Key-mask protection enabled |
| imask_en_i | input | 1 | Instruction key mask supported by the mode |
| done_o | output | 1 | Result valid |
| allow_o | output | 1 | Access allowed |
| fault_inst_o | output | 1 | Fetch fault |
| fault_data_o | output | 1 | Load or store fault |
| status_o | output | 5 | Fault status: 0 exec/guard, 1 protection, 2 key mask, 3 store, 4 segment |
| rights_o | output | 3 | Granted rights {x,w,r} |

## Verification
A single fault can have two causes at once, and both must be reported. A fetch can be refused by no-execute or guarded and by the instruction mask together. A store can be refused by the protection value and by the write bit of the data mask together. The bench sets both sources for the same request and expects both status bits in that one result cycle. It also checks that a refusal by the exec source hides the protection bit on a fetch, while the mask bit is still added.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  localparam int STAT_W   = 5;
  localparam int ST_EXEC  = 0;
  localparam int ST_PROT  = 1;
  localparam int ST_KEY   = 2;
  localparam int ST_STORE = 3;
  localparam int ST_SEG   = 4;
endpackage

// File: rtl/perm_pp_rights.sv
module perm_pp_rights
  import perm_chk_pkg::*;
(
  input  logic       key_i,
  input  logic [2:0] pp_i,
  output rights_t    rights_o
);
  always_comb begin
    rights_o = '0;
    if (!key_i) begin
      unique case (pp_i)
        3'd0, 3'd1, 3'd2: rights_o = '{x: 1'b1, w: 1'b1, r: 1'b1};
        3'd3, 3'd6:       rights_o = '{x: 1'b1, w: 1'b0, r: 1'b1};
        default:          rights_o = '0;
      endcase
    end else begin
      unique case (pp_i)
        3'd2:       rights_o = '{x: 1'b1, w: 1'b1, r: 1'b1};
        3'd1, 3'd3: rights_o = '{x: 1'b1, w: 1'b0, r: 1'b1};
        default:    rights_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/perm_key_mask.sv
module perm_key_mask
  import perm_chk_pkg::*;
#(
  parameter int MASK_W  = 64,
  localparam int FIELDS  = MASK_W / 2,
  localparam int CLASS_W = $clog2(FIELDS)
) (
  input  logic [CLASS_W-1:0] class_i,
  input  logic [MASK_W-1:0]  dmask_i,
  input  logic [MASK_W-1:0]  imask_i,
  input  logic               mask_en_i,
  input  logic               imask_en_i,
  output rights_t            rights_o
);
  logic [1:0] d_fld [FIELDS];
  logic [1:0] i_fld [FIELDS];

  // class k lives at bit 2*(FIELDS-1-k)
  for (genvar k = 0; k < FIELDS; k++) begin : g_fld
    assign d_fld[k] = dmask_i[2*(FIELDS-1-k) +: 2];
    assign i_fld[k] = imask_i[2*(FIELDS-1-k) +: 2];
  end

  logic [1:0] d_sel, i_sel;
  assign d_sel = d_fld[class_i];
  assign i_sel = i_fld[class_i];

  always_comb begin
    rights_o = '{x: 1'b1, w: 1'b1, r: 1'b1};
    if (mask_en_i) begin
      if (d_sel[1]) rights_o.w = 1'b0;
      if (d_sel[0]) rights_o.r = 1'b0;
      if (imask_en_i && i_sel[0]) rights_o.x = 1'b0;
    end
  end
endmodule

// File: rtl/perm_fault_enc.sv
module perm_fault_enc
  import perm_chk_pkg::*;
(
  input  logic [1:0]        acc_i,
  input  logic              seg_nx_i,
  input  rights_t           exec_src_i,
  input  rights_t           pp_src_i,
  input  rights_t           key_src_i,
  output rights_t           grant_o,
  output logic              allow_o,
  output logic              fault_i_o,
  output logic              fault_d_o,
  output logic [STAT_W-1:0] status_o
);
  rights_t need;
  logic    is_fetch, is_store;

  assign is_fetch = (acc_i == ACC_FETCH);
  assign is_store = (acc_i == ACC_STORE);
  assign grant_o  = exec_src_i & pp_src_i & key_src_i;

  always_comb begin
    need = '0;
    if (is_fetch)      need.x = 1'b1;
    else if (is_store) need.w = 1'b1;
    else               need.r = 1'b1;
  end

  always_comb begin
    allow_o   = 1'b0;
    fault_i_o = 1'b0;
    fault_d_o = 1'b0;
    status_o  = '0;
    if (is_fetch && seg_nx_i) begin
      fault_i_o        = 1'b1;
      status_o[ST_EXEC] = 1'b1;
      status_o[ST_SEG]  = 1'b1;
    end else if ((need & ~grant_o) == '0) begin
      allow_o = 1'b1;
    end else if (is_fetch) begin
      fault_i_o = 1'b1;
      if (!exec_src_i.x)    status_o[ST_EXEC] = 1'b1;
      else if (!pp_src_i.x) status_o[ST_PROT] = 1'b1;
      if (!key_src_i.x)     status_o[ST_KEY]  = 1'b1;
    end else begin
      fault_d_o          = 1'b1;
      status_o[ST_PROT]  = |(need & ~pp_src_i);
      status_o[ST_STORE] = is_store;
      status_o[ST_KEY]   = |(need & ~key_src_i);
    end
  end
endmodule

// File: rtl/perm_chk.sv
module perm_chk
  import perm_chk_pkg::*;
#(
  parameter int MASK_W  = 64,
  localparam int CLASS_W = $clog2(MASK_W / 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         acc_type_i,
  input  logic               user_mode_i,
  input  logic               seg_key_user_i,
  input  logic               seg_key_sup_i,
  input  logic               seg_noexec_i,
  input  logic [1:0]         pte_pp_i,
  input  logic               pte_pp0_i,
  input  logic               pte_noexec_i,
  input  logic               pte_guard_i,
  input  logic [CLASS_W-1:0] pte_class_i,
  input  logic [MASK_W-1:0]  dmask_i,
  input  logic [MASK_W-1:0]  imask_i,
  input  logic               mask_en_i,
  input  logic               imask_en_i,
  output logic               done_o,
  output logic               allow_o,
  output logic               fault_inst_o,
  output logic               fault_data_o,
  output logic [STAT_W-1:0]  status_o,
  output logic [2:0]         rights_o
);
  rights_t pp_src, key_src, exec_src, grant;
  logic    key_sel, allow_c, fi_c, fd_c;
  logic [STAT_W-1:0] stat_c;

  assign key_sel  = user_mode_i ? seg_key_user_i : seg_key_sup_i;
  assign exec_src = '{x: ~(pte_noexec_i | pte_guard_i), w: 1'b1, r: 1'b1};

  perm_pp_rights u_pp (
    .key_i    (key_sel),
    .pp_i     ({pte_pp0_i, pte_pp_i}),
    .rights_o (pp_src)
  );

  perm_key_mask #(.MASK_W(MASK_W)) u_km (
    .class_i    (pte_class_i),
    .dmask_i    (dmask_i),
    .imask_i    (imask_i),
    .mask_en_i  (mask_en_i),
    .imask_en_i (imask_en_i),
    .rights_o   (key_src)
  );

  perm_fault_enc u_enc (
    .acc_i      (acc_type_i),
    .seg_nx_i   (seg_noexec_i),
    .exec_src_i (exec_src),
    .pp_src_i   (pp_src),
    .key_src_i  (key_src),
    .grant_o    (grant),
    .allow_o    (allow_c),
    .fault_i_o  (fi_c),
    .fault_d_o  (fd_c),
    .status_o   (stat_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      allow_o      <= 1'b0;
      fault_inst_o <= 1'b0;
      fault_data_o <= 1'b0;
      status_o     <= '0;
      rights_o     <= '0;
    end else begin
      done_o       <= req_valid_i;
      allow_o      <= req_valid_i & allow_c;
      fault_inst_o <= req_valid_i & fi_c;
      fault_data_o <= req_valid_i & fd_c;
      status_o     <= req_valid_i ? stat_c : '0;
      rights_o     <= req_valid_i ? grant : '0;
    end
  end
endmodule

// File: rtl/perm_chk_sva.sv
module perm_chk_sva
  import perm_chk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        acc_type_i,
  input logic              seg_noexec_i,
  input logic              done_o,
  input logic              allow_o,
  input logic              fault_inst_o,
  input logic              fault_data_o,
  input logic [STAT_W-1:0] status_o,
  input logic [2:0]        rights_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!allow_o && !fault_inst_o && !fault_data_o && status_o == '0 && rights_o == '0));

  // R11
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({allow_o, fault_inst_o, fault_data_o}) == 1);

  // R11
  allow_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> status_o == '0);

  // R9
  data_no_exec_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_data_o |-> !status_o[ST_EXEC] && !status_o[ST_SEG]);

  // R8
  fetch_no_store_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_inst_o |-> !status_o[ST_STORE]);

  // R10
  seg_nx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_type_i == ACC_FETCH && seg_noexec_i)
      |=> (fault_inst_o && status_o == STAT_W'(5'b10001)));

  // R9
  store_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_type_i == ACC_STORE)
      |=> (allow_o || status_o[ST_STORE]));
endmodule

bind perm_chk perm_chk_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .acc_type_i   (acc_type_i),
  .seg_noexec_i (seg_noexec_i),
  .done_o       (done_o),
  .allow_o      (allow_o),
  .fault_inst_o (fault_inst_o),
  .fault_data_o (fault_data_o),
  .status_o     (status_o),
  .rights_o     (rights_o)
);

// File: tb/sim_perm_chk.sv
`timescale 1ns/1ps
module sim_perm_chk;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, umode = 0, ku = 0, ks = 0, snx = 0, pp0 = 0, pnx = 0, pg = 0, men = 0, ien = 0;
  logic [1:0] acc = 0, pp = 0;
  logic [4:0] cls = 0;
  logic [63:0] dm = 0, im = 0;
  logic done, allow, fi, fd;
  logic [4:0] st;
  logic [2:0] rt;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  perm_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .acc_type_i(acc),
    .user_mode_i(umode), .seg_key_user_i(ku), .seg_key_sup_i(ks), .seg_noexec_i(snx),
    .pte_pp_i(pp), .pte_pp0_i(pp0), .pte_noexec_i(pnx), .pte_guard_i(pg),
    .pte_class_i(cls), .dmask_i(dm), .imask_i(im), .mask_en_i(men), .imask_en_i(ien),
    .done_o(done), .allow_o(allow), .fault_inst_o(fi), .fault_data_o(fd),
    .status_o(st), .rights_o(rt)
  );

  // {done, allow, fi, fd, status[4:0], rights{x,w,r}}
  function automatic logic [11:0] model();
    logic k;
    logic [2:0] p, m, e, g, need;
    logic [4:0] s;
    logic [1:0] df, ifl;
    logic a, f_i, f_d;
    if (!req) return '0;
    k = umode ? ku : ks;
    case ({k, pp0, pp})
      4'b0000, 4'b0001, 4'b0010: p = 3'b111;
      4'b0011, 4'b0110:          p = 3'b101;
      4'b1010:                   p = 3'b111;
      4'b1001, 4'b1011:          p = 3'b101;
      default:                   p = 3'b000;
    endcase
    e = (pnx || pg) ? 3'b011 : 3'b111;
    df = dm[2*(31-cls) +: 2];
    ifl = im[2*(31-cls) +: 2];
    m = 3'b111;
    if (men && df[1]) m[1] = 0;
    if (men && df[0]) m[0] = 0;
    if (men && ien && ifl[0]) m[2] = 0;
    g = p & m & e;
    need = (acc == 2) ? 3'b100 : (acc == 1) ? 3'b010 : 3'b001;
    s = 0; a = 0; f_i = 0; f_d = 0;
    if (acc == 2 && snx) begin f_i = 1; s = 5'b10001; end
    else if ((need & ~g) == 0) a = 1;
    else if (acc == 2) begin
      f_i = 1;
      if (!e[2]) s[0] = 1; else if (!p[2]) s[1] = 1;
      if (!m[2]) s[2] = 1;
    end else begin
      f_d = 1;
      s[1] = |(need & ~p);
      s[3] = (acc == 1);
      s[2] = |(need & ~m);
    end
    return {1'b1, a, f_i, f_d, s, g};
  endfunction

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(string tag);
    logic [11:0] e;
    e = model();
    @(posedge clk);
    @(negedge clk);
    check(tag, {done, allow, fi, fd, st, rt}, e);
  endtask

  task automatic clr();
    req = 1; acc = 0; umode = 0; ku = 0; ks = 0; snx = 0; pp = 0; pp0 = 0;
    pnx = 0; pg = 0; cls = 0; dm = 0; im = 0; men = 0; ien = 0;
  endtask

  task automatic t_reset();
    req = 1;
    @(negedge clk);
    check("R1 reset", {done, allow, fi, fd, st, rt}, 12'h000);
    rst_n = 1;
    req = 0;
    run("R1 idle");
  endtask

  task automatic t_pp_table();
    logic [2:0] exp;
    for (int k = 0; k < 2; k++) begin
      for (int v = 0; v < 8; v++) begin
        clr(); ks = k[0]; {pp0, pp} = v[2:0];
        if (k == 0) exp = (v <= 2) ? 3'b111 : (v == 3 || v == 6) ? 3'b101 : 3'b000;
        else        exp = (v == 2) ? 3'b111 : (v == 1 || v == 3) ? 3'b101 : 3'b000;
        @(posedge clk); @(negedge clk);
        check(k == 0 ? "R2 pp key0" : "R3 pp key1", {9'h0, rt}, {9'h0, exp});
      end
    end
  endtask

  task automatic t_key_sel();
    clr(); umode = 1; ku = 1; ks = 0; run("R2 user key refuses");
    clr(); umode = 0; ku = 1; ks = 0; run("R2 sup key allows");
    clr(); umode = 0; ku = 0; ks = 1; pp = 2'd1; acc = 1; run("R7 store on read-only");
    clr(); acc = 3; pp0 = 1; pp = 2'd0; run("R7 code 3 as load");
  endtask

  task automatic t_nx_guard();
    clr(); pnx = 1; acc = 0; run("R4 nx keeps read");
    clr(); pg = 1; acc = 1; run("R4 guard keeps write");
    clr(); pg = 1; acc = 2; run("R8 guard fetch exec bit");
  endtask

  task automatic t_dmask();
    clr(); men = 1; cls = 5; dm[2*26 +: 2] = 2'b10; acc = 1; run("R5 write bit store");
    clr(); men = 1; cls = 5; dm[2*26 +: 2] = 2'b10; acc = 0; run("R5 write bit load ok");
    clr(); men = 1; cls = 5; dm[2*26 +: 2] = 2'b01; acc = 0; run("R5 read bit load");
    clr(); men = 1; cls = 5; dm[2*25 +: 2] = 2'b11; acc = 1; run("R5 other class ignored");
    clr(); men = 0; cls = 5; dm = '1; acc = 1; run("R5 disabled ignored");
    clr(); men = 1; cls = 0; dm[63:62] = 2'b01; run("R5 class 0 top field");
    clr(); men = 1; cls = 31; dm[1:0] = 2'b01; run("R5 class 31 bottom field");
  endtask

  task automatic t_imask();
    clr(); men = 1; ien = 1; cls = 9; im[2*22] = 1; acc = 2; run("R6 imask fetch");
    clr(); men = 1; ien = 0; cls = 9; im[2*22] = 1; acc = 2; run("R6 mode off");
    clr(); men = 0; ien = 1; cls = 9; im[2*22] = 1; acc = 2; run("R6 feature off");
    clr(); men = 1; ien = 1; cls = 9; im[2*22+1] = 1; acc = 2; run("R6 upper bit ignored");
  endtask

  task automatic t_fetch_enc();
    clr(); ks = 1; pnx = 1; acc = 2; run("R8 exec hides prot");
    clr(); ks = 1; acc = 2; run("R8 prot fetch");
    clr(); ks = 1; men = 1; ien = 1; cls = 3; im[2*28] = 1; acc = 2; run("R8 prot and key");
    clr(); pnx = 1; men = 1; ien = 1; cls = 3; im[2*28] = 1; acc = 2; run("R8 exec and key");
    clr(); acc = 2; run("R11 fetch allowed");
  endtask

  task automatic t_data_enc();
    clr(); ks = 1; acc = 0; run("R9 prot load");
    clr(); ks = 1; acc = 1; run("R9 prot store");
    clr(); pp = 2'd3; men = 1; cls = 7; dm[2*24 +: 2] = 2'b10; acc = 1; run("R9 prot key store");
    clr(); acc = 1; run("R11 store allowed");
  endtask

  task automatic t_seg();
    clr(); snx = 1; acc = 2; run("R10 seg fetch");
    clr(); snx = 1; ks = 1; pnx = 1; acc = 2; run("R10 seg hides others");
    clr(); snx = 1; acc = 0; run("R10 seg load ok");
    clr(); snx = 1; acc = 1; run("R10 seg store ok");
  endtask

  initial begin
    t_reset();
    t_pp_table();
    t_key_sel();
    t_nx_guard();
    t_dmask();
    t_imask();
    t_fetch_enc();
    t_data_enc();
    t_seg();
    req = 0;
    run("R1 back to idle");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule